// File: doc/BRIEF.md
# Debounced GPIO port controller

This block is an eight-pin general-purpose I/O port. Software programs it through a small register interface. Each pin has its own direction bit, output-drive style bit and output value bit. A five-bit code sets one debounce time that all pins share. Each pin connects to a tri-state style pad through three signals: an output enable, an output level and a sampled input.

A pin set as an input is synchronised into the clock domain. It is filtered by a counter that advances on a shared 1 ms strobe from an outside prescaler. A level is accepted only after it has stayed unchanged for the whole programmed time. Each accepted change raises a one-cycle flag on that pin for an external interrupt controller. While a pin drives, its filter follows the pad without raising any flag. When the pin is turned back into an input, any new level must again last a full debounce period.

Register map, selected by a two-bit address on both the write side and the read side:
- 0: direction (1 = output)
- 1: drive style (1 = push-pull, 0 = open-drain)
- 2: output value on write, debounced input on read
- 3: debounce code in bits [4:0]

Top module: `gpio_debounce_port`

## Requirements
- R1: After reset every pad output enable is 0, the change flags are 0, a read of address 2 returns 0 and a read of address 3 returns 0.
- R2: An input pin's debounced value, read at address 2, takes a new pad level only after 9 + code strobes have seen that level without a break. After 9 + code − 1 strobes it still shows the old value.
- R3: A pad level that returns to the debounced value before the count is complete is discarded. The next change must then be held for a full 9 + code strobes.
- R4: Only bits [4:0] of a write to address 3 are kept. The upper bits read back as 0. Code 31 needs 40 strobes.
- R5: While a pin is an output, its debounced value follows the pad and no change flag is raised. After the pin returns to input (direction bit written 0), a new level is taken only after 9 + code strobes, and no flag is raised at the moment of the switch.
- R6: A read of address 2 returns 0 for every pin whose direction bit is 1, whatever the pin is driving. For input pins it returns the debounced value.
- R7: For an output pin with drive-style bit 1 (push-pull), pad_oe is 1 and pad_out equals the value bit.
- R8: For an output pin with drive-style bit 0 (open-drain), value 1 gives pad_oe = 0 and value 0 gives pad_oe = 1 with pad_out = 0.
- R9: Each change of an input pin's debounced value raises that pin's change bit for exactly one clock cycle, in the cycle the new value first reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_ms | input | 1 | 1 ms strobe, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register select |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read register select |
| rd_data | output | 8 | Read data (combinational) |
| pad_in | input | 8 | Sampled pad levels |
| pad_oe | output | 8 | Pad output enables |
| pad_out | output | 8 | Pad output levels |
| change | output | 8 | One-cycle debounced-change flags |

## Verification
The bench samples the debounced value one strobe before the threshold and again exactly at it. A filter off by one strobe therefore fails, and so does one that ignores the code or keeps its upper bits. A pulse that falls short of the threshold is checked to leave no trace, which catches a counter that is not cleared when the level goes back. Turning a driven pin back into an input with a different outside level tests that the filter does not take the new level early and does not flag the switch. The bench also checks both open-drain and push-pull driving, and reads of output pins, which must return 0 and not the driven level.

// File: rtl/gpio_debounce_port.sv
module gpio_debounce_port #(
  parameter int N      = 8,
  parameter int CODE_W = 5,
  parameter int BASE   = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_ms,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [N-1:0] wr_data,
  input  logic [1:0]   rd_addr,
  output logic [N-1:0] rd_data,
  input  logic [N-1:0] pad_in,
  output logic [N-1:0] pad_oe,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] change
);
  localparam int CW = $clog2(BASE + (1 << CODE_W));

  logic [N-1:0]      dir, mode, val;
  logic [CODE_W-1:0] code;
  logic [N-1:0]      s1, s2, deb, deb_nxt;
  logic [CW-1:0]     cnt     [N];
  logic [CW-1:0]     cnt_nxt [N];
  logic [CW-1:0]     lim;

  assign lim = CW'(BASE) + CW'(code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir  <= '0;
      mode <= '0;
      val  <= '0;
      code <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: dir  <= wr_data;
        2'd1: mode <= wr_data;
        2'd2: val  <= wr_data;
        default: code <= wr_data[CODE_W-1:0];
      endcase
    end
  end

  assign pad_out = mode & val;
  assign pad_oe  = dir & (mode | ~val);

  always_comb begin
    case (rd_addr)
      2'd0: rd_data = dir;
      2'd1: rd_data = mode;
      2'd2: rd_data = deb & ~dir;
      default: rd_data = N'(code);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= pad_in;
      s2 <= s1;
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      deb_nxt[i] = deb[i];
      cnt_nxt[i] = cnt[i];
      if (dir[i]) begin
        deb_nxt[i] = s2[i];
        cnt_nxt[i] = '0;
      end else if (s2[i] == deb[i]) begin
        cnt_nxt[i] = '0;
      end else if (tick_ms) begin
        if (cnt[i] == lim - CW'(1)) begin
          deb_nxt[i] = s2[i];
          cnt_nxt[i] = '0;
        end else begin
          cnt_nxt[i] = cnt[i] + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deb    <= '0;
      change <= '0;
      for (int i = 0; i < N; i++) cnt[i] <= '0;
    end else begin
      deb    <= deb_nxt;
      change <= (deb ^ deb_nxt) & ~dir;
      for (int i = 0; i < N; i++) cnt[i] <= cnt_nxt[i];
    end
  end

  // R2
  deb_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((deb ^ $past(deb)) & ~$past(dir)) != '0) |-> $past(tick_ms));

  // R5
  no_flag_on_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (change & $past(dir)) == '0);

  // R9
  flag_matches_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    change == ((deb ^ $past(deb)) & ~$past(dir)));

  // R6
  out_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd2) |-> ((rd_data & dir) == '0));

  // R8
  od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_out & ~mode) == '0);

  generate
    for (genvar g = 0; g < N; g++) begin : g_bound
      // R2
      cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt[g] < lim);
    end
  endgenerate
endmodule

// File: tb/gpio_debounce_port_tb.sv
`timescale 1ns/1ps
module gpio_debounce_port_tb;
  logic       clk = 0, rst_n = 0, tick_ms = 0, wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data, pad_in, pad_oe, pad_out, change, ext = 0;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  gpio_debounce_port u_dut (.clk(clk), .rst_n(rst_n), .tick_ms(tick_ms),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .change(change));

  task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a; #0.5; d = rd_data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick1();
    @(negedge clk); tick_ms = 1;
    @(negedge clk); tick_ms = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick1();
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 oe", pad_oe, 8'h00);
    chk("R1 change", change, 8'h00);
    rd(2, d); chk("R1 value", d, 8'h00);
    rd(3, d); chk("R1 code", d, 8'h00);
  endtask

  task automatic t_debounce();
    logic [7:0] d;
    ext[0] = 1; idle(3);
    ticks(8);
    rd(2, d); chk("R2 before", d & 8'h01, 8'h00);
    tick1();
    chk("R9 pulse", change, 8'h01);
    rd(2, d); chk("R2 at limit", d & 8'h01, 8'h01);
    @(negedge clk);
    chk("R9 one cycle", change, 8'h00);
  endtask

  task automatic t_glitch();
    logic [7:0] d;
    wr(3, 8'h02);
    ext[1] = 1; idle(3); ticks(6);
    ext[1] = 0; idle(3); ticks(11);
    rd(2, d); chk("R3 glitch ignored", d & 8'h02, 8'h00);
    ext[1] = 1; idle(3); ticks(10);
    rd(2, d); chk("R3 full restart", d & 8'h02, 8'h00);
    tick1();
    rd(2, d); chk("R3 accepted", d & 8'h02, 8'h02);
  endtask

  task automatic t_code_max();
    logic [7:0] d;
    wr(3, 8'hFF);
    rd(3, d); chk("R4 code bits", d, 8'h1F);
    ext[2] = 1; idle(3); ticks(39);
    rd(2, d); chk("R4 39 strobes", d & 8'h04, 8'h00);
    tick1();
    rd(2, d); chk("R4 40 strobes", d & 8'h04, 8'h04);
  endtask

  task automatic t_drive();
    logic [7:0] d;
    wr(3, 8'h00);
    wr(1, 8'h01); wr(2, 8'h03); wr(0, 8'h03);
    chk("R7 pp high oe/out", {6'b0, pad_oe[0], pad_out[0]}, 8'h03);
    chk("R8 od released", {6'b0, pad_oe[1], pad_out[1]}, 8'h00);
    wr(2, 8'h00);
    chk("R7 pp low", {6'b0, pad_oe[0], pad_out[0]}, 8'h02);
    chk("R8 od low", {6'b0, pad_oe[1], pad_out[1]}, 8'h02);
    idle(4);
    rd(2, d); chk("R6 outputs read 0", d & 8'h07, 8'h04);
  endtask

  task automatic t_holdoff();
    logic [7:0] d;
    logic [7:0] seen;
    wr(0, 8'h01);
    wr(2, 8'h01);
    ext[0] = 0; idle(4);
    rd(2, d); chk("R6 driven high reads 0", d & 8'h01, 8'h00);
    seen = 0;
    wr(0, 8'h00);
    for (int i = 0; i < 4; i++) begin @(negedge clk); seen |= change; end
    chk("R5 no flag at switch", seen & 8'h01, 8'h00);
    rd(2, d); chk("R5 tracked level", d & 8'h01, 8'h01);
    ticks(8);
    rd(2, d); chk("R5 held off", d & 8'h01, 8'h01);
    tick1();
    chk("R5 flag after period", change & 8'h01, 8'h01);
    rd(2, d); chk("R5 new level", d & 8'h01, 8'h00);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1; idle(2);
    t_reset();
    t_debounce();
    t_glitch();
    t_code_max();
    t_drive();
    t_holdoff();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule